// File: doc/BRIEF.md
# Utility Write Decoder With Pulses and Latches

This block watches processor writes on a shared bus and acts only on writes to a single utility address in the X data space. The write data carries its own function selector. Bits 15:12 must read all ones for the write to count. Bits 11:8 then pick one of three actions. Code 0 loads an 8-bit parallel port with all bits at once. Code 1 sets or clears one line of an 8-line addressable latch. Codes 2 to 7 fire a short active-low strobe on the matching pulse line.

The upper data byte, bits 23:16, is a delay field used elsewhere in the system, and this decoder ignores it. Each strobe lasts a fixed, parameterized number of clock cycles. A strobe that is fired again while it is still active starts its count over. Each write is registered, so every output changes at the clock edge that samples the write.

Top module: `util_write_decoder`

## Requirements
- R1: A write is accepted only when `wrStb` is 1, `spaceX` is 1, `busAddr` equals `UTIL_ADDR` (default 16'hFFB0) and `busData[15:12]` is 4'hF. Any other bus activity leaves `portOut`, `latchOut` and `pulseN` unchanged.
- R2: An accepted write with `busData[11:8]` = 0 loads all eight bits of `portOut` from `busData[7:0]` at the clock edge that samples the write.
- R3: An accepted write with `busData[11:8]` = 1 sets `latchOut[busData[3:1]]` to `busData[0]` at the sampling edge.
- R4: A latch write changes no latch line other than the addressed one, so at most one bit of `latchOut` changes per cycle.
- R5: An accepted write with `busData[11:8]` = p, for p from 2 to 7, drives `pulseN[p]` low from the sampling edge for exactly `PULSE_CYCLES` clock cycles, after which it returns high.
- R6: A pulse write leaves every other pulse line, `portOut` and `latchOut` untouched. Pulse lines fired on different cycles run independently.
- R7: `busData[23:16]` has no effect on any output. On a latch write, `busData[7:4]` has no effect either.
- R8: An accepted write with `busData[11:8]` from 8 to 15 changes no output.
- R9: While `rstN` is low, `portOut` and `latchOut` are zero and every `pulseN` line is high.
- R10: Firing a pulse line again while it is low restarts its count, so the line stays low for `PULSE_CYCLES` cycles counted from the later write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | ADDR_W | Write address |
| busData | input | DATA_W | Write data word |
| wrStb | input | 1 | Write strobe, high for one cycle per write |
| spaceX | input | 1 | 1 selects X data space, 0 selects Y |
| portOut | output | 8 | Parallel port, loaded all at once |
| pulseN | output | 6 (7:2) | Active-low strobe lines 2 to 7 |
| latchOut | output | 8 | Bit-addressable latch lines |

## Verification
The assertions check on every cycle that only accepted writes move the port or latch, that a port load and a latch write land on the right value, that at most one latch bit flips, and that a pulse line can only fall right after an accepted pulse write. The strobe width, the restart of a strobe that is fired again, the independence of overlapping strobes, and the exact reset values are shown only by the bench's timed scenarios. The bench compares every output each cycle against a model kept in the bench.

// File: rtl/util_dec_pkg.sv
package util_dec_pkg;
  localparam int PORT_W      = 8;
  localparam int LATCH_N     = 8;
  localparam int LATCH_SEL_W = $clog2(LATCH_N);
  localparam int PULSE_FIRST = 2;
  localparam int PULSE_LAST  = 7;
  localparam logic [3:0] FUNC_UTIL  = 4'hF;
  localparam logic [3:0] CODE_PORT  = 4'h0;
  localparam logic [3:0] CODE_LATCH = 4'h1;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic                          portLoad;
    logic [PORT_W-1:0]             portVal;
    logic                          latchWr;
    logic [LATCH_SEL_W-1:0]        latchSel;
    logic                          latchBit;
    logic [PULSE_LAST:PULSE_FIRST] pulseFire;
  } utilStrb_t;
endpackage

// File: rtl/util_dec_ctrl.sv
module util_dec_ctrl
  import util_dec_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 24,
  parameter logic [ADDR_W-1:0] UTIL_ADDR = 16'hFFB0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              wrStb,
  input  logic              spaceX,
  output utilStrb_t         strb
);
  logic       hit;
  logic [3:0] funcSel;
  logic [3:0] code;
  logic       unusedDelay;

  assign funcSel     = busData[15:12];
  assign code        = busData[11:8];
  // Delay field is consumed elsewhere in the system
  assign unusedDelay = ^busData[DATA_W-1:16];

  assign hit = wrStb && spaceX && (busAddr == UTIL_ADDR) && (funcSel == FUNC_UTIL);

  always_comb begin
    strb          = '0;
    strb.portVal  = busData[PORT_W-1:0];
    strb.latchSel = busData[LATCH_SEL_W:1];
    strb.latchBit = busData[0];
    strb.portLoad = hit && (code == CODE_PORT);
    strb.latchWr  = hit && (code == CODE_LATCH);
    for (int i = PULSE_FIRST; i <= PULSE_LAST; i++) begin
      strb.pulseFire[i] = hit && (code == 4'(i));
    end
  end
endmodule

// File: rtl/util_dec_datapath.sv
module util_dec_datapath
  import util_dec_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  utilStrb_t                     strb,
  output logic [PORT_W-1:0]             portOut,
  output logic [PULSE_LAST:PULSE_FIRST] pulseN,
  output logic [LATCH_N-1:0]            latchOut
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portOut <= '0;
    end else if (strb.portLoad) begin
      portOut <= strb.portVal;
    end
  end

  genvar li;
  generate
    for (li = 0; li < LATCH_N; li++) begin : g_latch
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          latchOut[li] <= 1'b0;
        end else if (strb.latchWr && (strb.latchSel == LATCH_SEL_W'(li))) begin
          latchOut[li] <= strb.latchBit;
        end
      end
    end
  endgenerate

  genvar pi;
  generate
    for (pi = PULSE_FIRST; pi <= PULSE_LAST; pi++) begin : g_pulse
      logic [CNT_W-1:0] remain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          remain <= '0;
        end else if (strb.pulseFire[pi]) begin
          remain <= CNT_LOAD;
        end else if (remain != '0) begin
          remain <= remain - 1'b1;
        end
      end
      assign pulseN[pi] = (remain == '0);
    end
  endgenerate
endmodule

// File: rtl/util_write_decoder.sv
module util_write_decoder
  import util_dec_pkg::*;
#(
  parameter int                ADDR_W       = 16,
  parameter int                DATA_W       = 24,
  parameter logic [ADDR_W-1:0] UTIL_ADDR    = 16'hFFB0,
  parameter int                PULSE_CYCLES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [DATA_W-1:0]             busData,
  input  logic                          wrStb,
  input  logic                          spaceX,
  output logic [PORT_W-1:0]             portOut,
  output logic [PULSE_LAST:PULSE_FIRST] pulseN,
  output logic [LATCH_N-1:0]            latchOut
);
  utilStrb_t strb;

  util_dec_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UTIL_ADDR(UTIL_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busData(busData), .wrStb(wrStb), .spaceX(spaceX), .strb(strb)
  );

  util_dec_datapath #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .portOut(portOut), .pulseN(pulseN), .latchOut(latchOut)
  );
endmodule

// File: rtl/util_write_decoder_chk.sv
module util_write_decoder_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 24,
  parameter logic [ADDR_W-1:0] UTIL_ADDR = 16'hFFB0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busData,
  input logic              wrStb,
  input logic              spaceX,
  input logic [7:0]        portOut,
  input logic [7:2]        pulseN,
  input logic [7:0]        latchOut
);
  logic       hit;
  logic       hitPulse;
  logic [3:0] code;
  logic       unusedChk;

  assign unusedChk = ^busData[DATA_W-1:16];
  assign code      = busData[11:8];
  assign hit       = wrStb && spaceX && (busAddr == UTIL_ADDR) && (busData[15:12] == 4'hF);
  assign hitPulse  = hit && (code >= 4'd2) && (code <= 4'd7);

  a_r1_quiet_without_hit: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> ($stable(portOut) && $stable(latchOut)));

  a_r2_port_load: assert property (@(posedge clk) disable iff (!rstN)
    (hit && code == 4'd0) |=> (portOut == $past(busData[7:0])));

  a_r3_latch_value: assert property (@(posedge clk) disable iff (!rstN)
    (hit && code == 4'd1) |=> (latchOut[$past(busData[3:1])] == $past(busData[0])));

  a_r4_single_latch_flip: assert property (@(posedge clk) disable iff (!rstN)
    $countones(latchOut ^ $past(latchOut)) <= 1);

  a_r6_pulse_falls_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(pulseN) & ~pulseN)) |-> $past(hitPulse));

  a_r8_high_codes_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (hit && code[3]) |=> ($stable(portOut) && $stable(latchOut)));
endmodule

bind util_write_decoder util_write_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UTIL_ADDR(UTIL_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .wrStb(wrStb),
  .spaceX(spaceX), .portOut(portOut), .pulseN(pulseN), .latchOut(latchOut)
);

// File: tb/util_write_decoder_bench.sv
module util_write_decoder_bench;
  localparam int PCYC = 4;
  localparam logic [15:0] UADDR = 16'hFFB0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [23:0] busData = '0;
  logic        wrStb = 1'b0;
  logic        spaceX = 1'b0;
  logic [7:0]  portOut;
  logic [7:2]  pulseN;
  logic [7:0]  latchOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R9";
  logic [7:0] expPort = '0;
  logic [7:0] expLatch = '0;
  int remain [8];

  always #5 clk = ~clk;

  util_write_decoder #(.PULSE_CYCLES(PCYC)) u_util_write_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .wrStb(wrStb),
    .spaceX(spaceX), .portOut(portOut), .pulseN(pulseN), .latchOut(latchOut)
  );

  function automatic logic [7:2] expPulse();
    logic [7:2] v;
    for (int i = 2; i <= 7; i++) v[i] = (remain[i] == 0);
    return v;
  endfunction

  task automatic compareAll();
    checks++;
    if (portOut !== expPort) begin
      errors++;
      $display("FAIL %s portOut actual=%h expected=%h", curReq, portOut, expPort);
    end
    checks++;
    if (latchOut !== expLatch) begin
      errors++;
      $display("FAIL %s latchOut actual=%h expected=%h", curReq, latchOut, expLatch);
    end
    checks++;
    if (pulseN !== expPulse()) begin
      errors++;
      $display("FAIL %s pulseN actual=%b expected=%b", curReq, pulseN, expPulse());
    end
  endtask

  // One clock: model the edge from the driven inputs, then sample at negedge
  task automatic tick();
    logic hit;
    logic [3:0] code;
    @(posedge clk);
    hit  = wrStb && spaceX && (busAddr == UADDR) && (busData[15:12] == 4'hF);
    code = busData[11:8];
    for (int i = 2; i <= 7; i++) begin
      if (hit && code == 4'(i)) remain[i] = PCYC;
      else if (remain[i] > 0) remain[i] = remain[i] - 1;
    end
    if (hit && code == 4'd0) expPort = busData[7:0];
    if (hit && code == 4'd1) expLatch[busData[3:1]] = busData[0];
    @(negedge clk);
    compareAll();
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [23:0] d, input logic x, input logic s);
    busAddr = a; busData = d; spaceX = x; wrStb = s;
    tick();
    wrStb = 1'b0; busData = '0; busAddr = '0; spaceX = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) remain[i] = 0;
    // R9: reset values
    repeat (3) @(negedge clk);
    curReq = "R9";
    compareAll();
    rstN = 1'b1;
    idle(2);

    // R2: port loads over a sweep of values
    curReq = "R2";
    for (int v = 0; v < 256; v += 17) busWrite(UADDR, {8'h00, 8'hF0, 8'(v)}, 1'b1, 1'b1);
    busWrite(UADDR, 24'h00F0A5, 1'b1, 1'b1);

    // R3 R4: every latch address, set then clear
    curReq = "R3 R4";
    for (int n = 0; n < 16; n++) busWrite(UADDR, {8'h00, 8'hF1, 4'h0, 4'(n)}, 1'b1, 1'b1);
    for (int n = 0; n < 16; n += 2) busWrite(UADDR, {8'h00, 8'hF1, 4'h0, 4'(n)}, 1'b1, 1'b1);
    for (int n = 1; n < 16; n += 4) busWrite(UADDR, {8'h00, 8'hF1, 4'h0, 4'(n)}, 1'b1, 1'b1);

    // R7: delay field and upper nibble of latch data have no effect
    curReq = "R7";
    for (int d = 0; d < 256; d += 51) begin
      busWrite(UADDR, {8'(d), 8'hF1, 4'(d), 4'(d)}, 1'b1, 1'b1);
      busWrite(UADDR, {8'(d), 8'hF0, 8'(d ^ 8'h3C)}, 1'b1, 1'b1);
    end

    // R5 R6: each pulse line, with port and latch held
    curReq = "R5 R6";
    for (int p = 2; p <= 7; p++) begin
      busWrite(UADDR, {8'hFF, 4'hF, 4'(p), 8'h5A}, 1'b1, 1'b1);
      idle(PCYC + 2);
    end

    // R6: overlapping pulses on different lines
    busWrite(UADDR, 24'h00F200, 1'b1, 1'b1);
    busWrite(UADDR, 24'h00F500, 1'b1, 1'b1);
    idle(1);
    busWrite(UADDR, 24'h00F700, 1'b1, 1'b1);
    idle(PCYC + 2);

    // R10: retrigger restarts the count
    curReq = "R10";
    busWrite(UADDR, 24'h00F400, 1'b1, 1'b1);
    idle(2);
    busWrite(UADDR, 24'h00F400, 1'b1, 1'b1);
    idle(PCYC + 2);

    // R8: reserved codes
    curReq = "R8";
    for (int c = 8; c < 16; c++) begin
      busWrite(UADDR, {8'h00, 4'hF, 4'(c), 8'hC3}, 1'b1, 1'b1);
    end
    idle(2);

    // R1: rejected writes of every kind
    curReq = "R1";
    for (int f = 0; f < 15; f++) begin
      busWrite(UADDR, {8'h00, 4'(f), 4'h0, 8'h99}, 1'b1, 1'b1);
      busWrite(UADDR, {8'h00, 4'(f), 4'h1, 8'h0F}, 1'b1, 1'b1);
      busWrite(UADDR, {8'h00, 4'(f), 4'h3, 8'h00}, 1'b1, 1'b1);
    end
    busWrite(16'hFFB1, 24'h00F066, 1'b1, 1'b1);
    busWrite(16'h7FB0, 24'h00F10E, 1'b1, 1'b1);
    busWrite(16'h0000, 24'h00F600, 1'b1, 1'b1);
    busWrite(UADDR, 24'h00F077, 1'b0, 1'b1);
    busWrite(UADDR, 24'h00F20F, 1'b0, 1'b1);
    busWrite(UADDR, 24'h00F088, 1'b1, 1'b0);
    busWrite(UADDR, 24'h00F10F, 1'b1, 1'b0);
    busWrite(UADDR, 24'h00F300, 1'b1, 1'b0);
    idle(PCYC + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule